// File: doc/BRIEF.md
# Pipelined DES Engine with Per-Word Key and Mode

This block is a 64-bit DES engine that takes a new word on every clock cycle. Each word arrives with its own 64-bit key and a 2-bit operation code, so encryption, decryption and pass-through can be freely mixed on consecutive cycles. Each of the sixteen Feistel rounds has its own register stage. The round subkeys are derived in a key lane that advances beside the data, so a key change never costs a setup cycle.

A user sideband field enters with each word and leaves on the same cycle as that word's result. A valid flag moves through the pipe in the same way. The output ports mirror the input ports. Three copies can therefore be wired output to input to form a three-key triple-DES datapath: the keys and the operation for the later copies ride in the sideband field. Block-chaining modes and padding belong to the logic around the engine.

Top module: `des_pipe`

## Requirements
- R1: With `inMode` = 2'b00 the result is the standard DES encryption of `inData` under `inKey`. Key parity bits are ignored, and bit 63 is the first bit of the word.
- R2: With `inMode` = 2'b01 the result is the standard DES decryption of `inData` under `inKey`, so decrypting a ciphertext returns the original plaintext.
- R3: With `inMode[1]` = 1 (codes 2'b10 and 2'b11) the result equals `inData` unchanged, after the same latency as the cipher modes.
- R4: A word sampled with `inValid` high on a rising edge appears on `outData` with `outValid` high exactly 17 cycles later. One word is accepted every cycle with no stall, and results leave in input order.
- R5: The key and mode sampled with a word apply to that word only. Words with different keys and modes on back-to-back cycles each produce their own correct result.
- R6: The `inSide` value sampled with a word appears on `outSide` in the same cycle as that word's result.
- R7: A cycle with `inValid` low never raises `outValid` 17 cycles later, while the neighbouring valid words keep their timing.
- R8: A synchronous `rst` clears `outValid` on the next edge and discards every word in flight. None of those words appears at the output afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| inValid | input | 1 | Marks the input word of this cycle as real |
| inMode | input | 2 | 00 encrypt, 01 decrypt, 1x pass-through |
| inKey | input | 64 | Key for this word (parity bits unused) |
| inData | input | 64 | Input block |
| inSide | input | SB_W | User control field carried with the word |
| outValid | output | 1 | Marks outData/outSide as a result |
| outData | output | 64 | Result block |
| outSide | output | SB_W | Sideband of the word whose result is on outData |

## Verification
A wrong subkey rotation or a misrouted S-box bit corrupts every cipher result. A cipher result leaves 17 cycles after its input, so such a fault shows up at the first known-answer word and gives a ciphertext that differs in about half its bits. If the mode or key lane slips against the data by one stage, the fault appears only when neighbouring words differ in key or mode, which is why the stimulus mixes both on back-to-back cycles and checks the encrypt-then-decrypt round trip. A fault in valid or sideband staging moves `outValid` or `outSide` off the cycle the reference model predicts, and the model compares these on every clock.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int NROUND  = 16;
  localparam int LATENCY = NROUND + 1;

  typedef struct packed {
    logic dec;
    logic byp;
  } stage_ctl_t;

  localparam int IP_T [64] = '{
    58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
    62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
    57, 49, 41, 33, 25, 17,  9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
    61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};
  localparam int FP_T [64] = '{
    40, 8, 48, 16, 56, 24, 64, 32, 39, 7, 47, 15, 55, 23, 63, 31,
    38, 6, 46, 14, 54, 22, 62, 30, 37, 5, 45, 13, 53, 21, 61, 29,
    36, 4, 44, 12, 52, 20, 60, 28, 35, 3, 43, 11, 51, 19, 59, 27,
    34, 2, 42, 10, 50, 18, 58, 26, 33, 1, 41,  9, 49, 17, 57, 25};
  localparam int E_T [48] = '{
    32,  1,  2,  3,  4,  5,  4,  5,  6,  7,  8,  9,  8,  9, 10, 11,
    12, 13, 12, 13, 14, 15, 16, 17, 16, 17, 18, 19, 20, 21, 20, 21,
    22, 23, 24, 25, 24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32,  1};
  localparam int P_T [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2, 8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};
  localparam int PC1_T [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
  localparam int PC2_T [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
  localparam int SHIFT_T [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

  localparam int S1_T [64] = '{
    14, 4, 13, 1, 2, 15, 11, 8, 3, 10, 6, 12, 5, 9, 0, 7,
    0, 15, 7, 4, 14, 2, 13, 1, 10, 6, 12, 11, 9, 5, 3, 8,
    4, 1, 14, 8, 13, 6, 2, 11, 15, 12, 9, 7, 3, 10, 5, 0,
    15, 12, 8, 2, 4, 9, 1, 7, 5, 11, 3, 14, 10, 0, 6, 13};
  localparam int S2_T [64] = '{
    15, 1, 8, 14, 6, 11, 3, 4, 9, 7, 2, 13, 12, 0, 5, 10,
    3, 13, 4, 7, 15, 2, 8, 14, 12, 0, 1, 10, 6, 9, 11, 5,
    0, 14, 7, 11, 10, 4, 13, 1, 5, 8, 12, 6, 9, 3, 2, 15,
    13, 8, 10, 1, 3, 15, 4, 2, 11, 6, 7, 12, 0, 5, 14, 9};
  localparam int S3_T [64] = '{
    10, 0, 9, 14, 6, 3, 15, 5, 1, 13, 12, 7, 11, 4, 2, 8,
    13, 7, 0, 9, 3, 4, 6, 10, 2, 8, 5, 14, 12, 11, 15, 1,
    13, 6, 4, 9, 8, 15, 3, 0, 11, 1, 2, 12, 5, 10, 14, 7,
    1, 10, 13, 0, 6, 9, 8, 7, 4, 15, 14, 3, 11, 5, 2, 12};
  localparam int S4_T [64] = '{
    7, 13, 14, 3, 0, 6, 9, 10, 1, 2, 8, 5, 11, 12, 4, 15,
    13, 8, 11, 5, 6, 15, 0, 3, 4, 7, 2, 12, 1, 10, 14, 9,
    10, 6, 9, 0, 12, 11, 7, 13, 15, 1, 3, 14, 5, 2, 8, 4,
    3, 15, 0, 6, 10, 1, 13, 8, 9, 4, 5, 11, 12, 7, 2, 14};
  localparam int S5_T [64] = '{
    2, 12, 4, 1, 7, 10, 11, 6, 8, 5, 3, 15, 13, 0, 14, 9,
    14, 11, 2, 12, 4, 7, 13, 1, 5, 0, 15, 10, 3, 9, 8, 6,
    4, 2, 1, 11, 10, 13, 7, 8, 15, 9, 12, 5, 6, 3, 0, 14,
    11, 8, 12, 7, 1, 14, 2, 13, 6, 15, 0, 9, 10, 4, 5, 3};
  localparam int S6_T [64] = '{
    12, 1, 10, 15, 9, 2, 6, 8, 0, 13, 3, 4, 14, 7, 5, 11,
    10, 15, 4, 2, 7, 12, 9, 5, 6, 1, 13, 14, 0, 11, 3, 8,
    9, 14, 15, 5, 2, 8, 12, 3, 7, 0, 4, 10, 1, 13, 11, 6,
    4, 3, 2, 12, 9, 5, 15, 10, 11, 14, 1, 7, 6, 0, 8, 13};
  localparam int S7_T [64] = '{
    4, 11, 2, 14, 15, 0, 8, 13, 3, 12, 9, 7, 5, 10, 6, 1,
    13, 0, 11, 7, 4, 9, 1, 10, 14, 3, 5, 12, 2, 15, 8, 6,
    1, 4, 11, 13, 12, 3, 7, 14, 10, 15, 6, 8, 0, 5, 9, 2,
    6, 11, 13, 8, 1, 4, 10, 7, 9, 5, 0, 15, 14, 2, 3, 12};
  localparam int S8_T [64] = '{
    13, 2, 8, 4, 6, 15, 11, 1, 10, 9, 3, 14, 5, 0, 12, 7,
    1, 15, 13, 8, 10, 3, 7, 4, 12, 5, 6, 11, 0, 14, 9, 2,
    7, 11, 4, 1, 9, 12, 14, 2, 0, 6, 10, 13, 15, 3, 5, 8,
    2, 1, 14, 7, 4, 10, 8, 13, 15, 12, 9, 0, 3, 5, 6, 11};

  // Table entries count bits from 1 at the MSB.
  function automatic logic [63:0] ipPerm(input logic [63:0] x);
    for (int i = 0; i < 64; i++) ipPerm[6'(63 - i)] = x[6'(64 - IP_T[i])];
  endfunction

  function automatic logic [63:0] fpPerm(input logic [63:0] x);
    for (int i = 0; i < 64; i++) fpPerm[6'(63 - i)] = x[6'(64 - FP_T[i])];
  endfunction

  function automatic logic [47:0] ePerm(input logic [31:0] x);
    for (int i = 0; i < 48; i++) ePerm[6'(47 - i)] = x[5'(32 - E_T[i])];
  endfunction

  function automatic logic [31:0] pPerm(input logic [31:0] x);
    for (int i = 0; i < 32; i++) pPerm[5'(31 - i)] = x[5'(32 - P_T[i])];
  endfunction

  function automatic logic [55:0] pc1Perm(input logic [63:0] k);
    for (int i = 0; i < 56; i++) pc1Perm[6'(55 - i)] = k[6'(64 - PC1_T[i])];
  endfunction

  function automatic logic [47:0] pc2Perm(input logic [55:0] cd);
    for (int i = 0; i < 48; i++) pc2Perm[6'(47 - i)] = cd[6'(56 - PC2_T[i])];
  endfunction

  function automatic logic [27:0] rotl28(input logic [27:0] x, input int n);
    logic [55:0] t;
    t = {x, x} << n;
    return t[55:28];
  endfunction

  // Outer bits pick the row, inner four bits the column.
  function automatic logic [3:0] sboxLook(input int box, input logic [5:0] six);
    logic [5:0] idx;
    idx = {six[5], six[0], six[4:1]};
    case (box)
      0: return 4'(S1_T[idx]);
      1: return 4'(S2_T[idx]);
      2: return 4'(S3_T[idx]);
      3: return 4'(S4_T[idx]);
      4: return 4'(S5_T[idx]);
      5: return 4'(S6_T[idx]);
      6: return 4'(S7_T[idx]);
      default: return 4'(S8_T[idx]);
    endcase
  endfunction

endpackage

// File: rtl/des_round.sv
module des_round
  import des_pkg::*;
#(
  parameter int RND = 1
) (
  input  logic [31:0] lIn,
  input  logic [31:0] rIn,
  input  logic [55:0] cdIn,
  input  stage_ctl_t  ctl,
  output logic [31:0] lOut,
  output logic [31:0] rOut,
  output logic [55:0] cdOut
);
  // Forward schedule rotates left. The reverse schedule starts on the unrotated
  // halves and rotates right by the mirrored amounts.
  localparam int ENC_AMT = SHIFT_T[RND - 1];
  localparam int DEC_AMT = (RND == 1) ? 0 : SHIFT_T[(17 - RND) % 16];

  logic [27:0] cNew, dNew;
  logic [47:0] subKey, mixed;
  logic [31:0] sOut;

  always_comb begin
    if (ctl.dec) begin
      cNew = rotl28(cdIn[55:28], 28 - DEC_AMT);
      dNew = rotl28(cdIn[27:0], 28 - DEC_AMT);
    end else begin
      cNew = rotl28(cdIn[55:28], ENC_AMT);
      dNew = rotl28(cdIn[27:0], ENC_AMT);
    end
    subKey = pc2Perm({cNew, dNew});
    mixed  = ePerm(rIn) ^ subKey;
  end

  for (genvar j = 0; j < 8; j++) begin : g_sbox
    assign sOut[31 - 4*j -: 4] = sboxLook(j, mixed[47 - 6*j -: 6]);
  end

  assign cdOut = {cNew, dNew};

  always_comb begin
    if (ctl.byp) begin
      lOut = lIn;
      rOut = rIn;
    end else begin
      lOut = rIn;
      rOut = lIn ^ pPerm(sOut);
    end
  end

endmodule

// File: rtl/des_ctrl.sv
module des_ctrl
  import des_pkg::*;
#(
  parameter int SB_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic [1:0]                  inMode,
  input  logic [SB_W-1:0]             inSide,
  output stage_ctl_t [NROUND-1:0]     stCtl,
  output logic                        lastByp,
  output logic                        outValid,
  output logic [SB_W-1:0]             outSide
);
  logic [NROUND:1]            vldQ;
  logic [NROUND:1]            bypQ;
  logic [NROUND-1:1]          decQ;
  logic [NROUND:1][SB_W-1:0]  sideQ;
  logic                       inDec, inByp;

  assign inDec = (inMode == 2'b01);
  assign inByp = inMode[1];

  assign stCtl[0] = '{dec: inDec, byp: inByp};
  for (genvar i = 1; i < NROUND; i++) begin : g_strobe
    assign stCtl[i] = '{dec: decQ[i], byp: bypQ[i]};
  end
  assign lastByp = bypQ[NROUND];

  always_ff @(posedge clk) begin
    if (rst) begin
      vldQ     <= '0;
      outValid <= 1'b0;
    end else begin
      vldQ     <= {vldQ[NROUND-1:1], inValid};
      outValid <= vldQ[NROUND];
    end
  end

  always_ff @(posedge clk) begin
    bypQ    <= {bypQ[NROUND-1:1], inByp};
    decQ    <= {decQ[NROUND-2:1], inDec};
    sideQ   <= {sideQ[NROUND-1:1], inSide};
    outSide <= sideQ[NROUND];
  end

  logic [4:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 5'(LATENCY)) warm <= warm + 5'd1;
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 5'(LATENCY)) |-> (outValid == $past(inValid, LATENCY)));

  // R6
  side_align_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 5'(LATENCY) && outValid) |-> (outSide == $past(inSide, LATENCY)));

endmodule

// File: rtl/des_dpath.sv
module des_dpath
  import des_pkg::*;
(
  input  logic                    clk,
  input  logic [63:0]             inData,
  input  logic [63:0]             inKey,
  input  stage_ctl_t [NROUND-1:0] stCtl,
  input  logic                    lastByp,
  output logic [63:0]             outData
);
  logic [NROUND-1:0][31:0] lSrc, rSrc, lNx, rNx;
  logic [NROUND-1:0][55:0] cdSrc, cdNx;
  logic [NROUND:1][31:0]   lQ, rQ;
  logic [NROUND-1:1][55:0] cdQ;
  logic [63:0]             ipVal;

  assign ipVal = ipPerm(inData);

  for (genvar r = 0; r < NROUND; r++) begin : g_round
    if (r == 0) begin : g_head
      assign lSrc[r]  = ipVal[63:32];
      assign rSrc[r]  = ipVal[31:0];
      assign cdSrc[r] = pc1Perm(inKey);
    end else begin : g_body
      assign lSrc[r]  = lQ[r];
      assign rSrc[r]  = rQ[r];
      assign cdSrc[r] = cdQ[r];
    end
    des_round #(.RND(r + 1)) u_rnd (
      .lIn  (lSrc[r]),
      .rIn  (rSrc[r]),
      .cdIn (cdSrc[r]),
      .ctl  (stCtl[r]),
      .lOut (lNx[r]),
      .rOut (rNx[r]),
      .cdOut(cdNx[r])
    );
  end

  always_ff @(posedge clk) begin
    lQ  <= lNx;
    rQ  <= rNx;
    cdQ <= cdNx[NROUND-2:0];
    outData <= fpPerm(lastByp ? {lQ[NROUND], rQ[NROUND]} : {rQ[NROUND], lQ[NROUND]});
  end

  logic unusedKey;
  assign unusedKey = ^cdNx[NROUND-1];

endmodule

// File: rtl/des_pipe.sv
module des_pipe
  import des_pkg::*;
#(
  parameter int SB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [1:0]      inMode,
  input  logic [63:0]     inKey,
  input  logic [63:0]     inData,
  input  logic [SB_W-1:0] inSide,
  output logic            outValid,
  output logic [63:0]     outData,
  output logic [SB_W-1:0] outSide
);
  stage_ctl_t [NROUND-1:0] stCtl;
  logic                    lastByp;

  des_ctrl #(.SB_W(SB_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inMode  (inMode),
    .inSide  (inSide),
    .stCtl   (stCtl),
    .lastByp (lastByp),
    .outValid(outValid),
    .outSide (outSide)
  );

  des_dpath u_dpath (
    .clk    (clk),
    .inData (inData),
    .inKey  (inKey),
    .stCtl  (stCtl),
    .lastByp(lastByp),
    .outData(outData)
  );

  logic [4:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 5'(LATENCY)) warm <= warm + 5'd1;
  end

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 5'(LATENCY) && $past(inValid && inMode[1], LATENCY))
      |-> (outData == $past(inData, LATENCY)));

endmodule

// File: tb/sim_des_pipe.sv
module sim_des_pipe;
  localparam int SB_W = 8;
  localparam int LAT  = 17;
  localparam int NRT  = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic [1:0]      inMode = 2'b00;
  logic [63:0]     inKey = '0, inData = '0;
  logic [SB_W-1:0] inSide = '0;
  logic            outValid;
  logic [63:0]     outData;
  logic [SB_W-1:0] outSide;

  always #5 clk = ~clk;

  des_pipe #(.SB_W(SB_W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode), .inKey(inKey),
    .inData(inData), .inSide(inSide), .outValid(outValid), .outData(outData),
    .outSide(outSide)
  );

  typedef struct {
    logic [63:0]     data;
    logic [SB_W-1:0] side;
    int              due;
    bit              known;
    string           req;
  } exp_t;

  exp_t        expQ[$];
  logic [63:0] seen[$];
  int          nChk = 0, nFail = 0, cyc = 0;
  logic [SB_W-1:0] sideCnt = '0;

  logic [63:0] katK [5] = '{64'h133457799BBCDFF1, 64'h0E329232EA6D0D73,
                            64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
                            64'h1111111111111111};
  logic [63:0] katP [5] = '{64'h0123456789ABCDEF, 64'h8787878787878787,
                            64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
                            64'h1111111111111111};
  logic [63:0] katC [5] = '{64'h85E813540F0AB405, 64'h0000000000000000,
                            64'h8CA64DE9C1B123A7, 64'h7359B2163E4EDC58,
                            64'hF40379AB9E0EC533};
  logic [63:0] rtKey [NRT];
  logic [63:0] rtPt  [NRT];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic sampleOut();
    bit expV;
    expV = (expQ.size() > 0) && (expQ[0].due == cyc);
    if (rst) chk(outValid === 1'b0, "R8 outValid in reset", 64'(outValid), 64'd0);
    chk(outValid === expV, expV ? "R4 outValid timing" : "R7 idle slot valid",
        64'(outValid), 64'(expV));
    if (expV) begin
      exp_t e;
      e = expQ.pop_front();
      chk(outSide === e.side, "R6 sideband", 64'(outSide), 64'(e.side));
      if (e.known) chk(outData === e.data, e.req, outData, e.data);
      else seen.push_back(outData);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [1:0] m, input logic [63:0] k,
                      input logic [63:0] d, input logic [63:0] expD, input bit known,
                      input string req);
    @(negedge clk);
    cyc++;
    sampleOut();
    if (r) expQ.delete();
    rst     = r;
    inValid = v;
    inMode  = m;
    inKey   = k;
    inData  = d;
    inSide  = sideCnt;
    if (v && !r) expQ.push_back('{data: expD, side: sideCnt, due: cyc + LAT, known: known, req: req});
    sideCnt = sideCnt + 8'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'b00, 64'hDEAD_BEEF_0BAD_F00D, 64'hA5A5_5A5A_C3C3_3C3C, '0, 1'b0, "R7");
  endtask

  initial begin
    // R8: outputs idle while reset is held
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'b00, '0, '0, '0, 1'b0, "R8");
    idle(2);

    // R1 R2 R3 R5: known answers with key and mode changing every cycle
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1, 2'b00, katK[i], katP[i], katC[i], 1'b1, "R1 R5 encrypt KAT");
      step(1'b0, 1'b1, 2'b01, katK[i], katC[i], katP[i], 1'b1, "R2 R5 decrypt KAT");
      step(1'b0, 1'b1, 2'b10, katK[i], katC[i], katC[i], 1'b1, "R3 bypass code 10");
      step(1'b0, 1'b1, 2'b11, ~katK[i], katP[i], katP[i], 1'b1, "R3 bypass code 11");
    end

    // R7: valid words separated by invalid slots
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1, 2'b00, katK[i], katP[i], katC[i], 1'b1, "R1 R7 encrypt among gaps");
      idle(i % 3);
    end
    idle(LAT + 3);

    // R2 R5: round trip with random keys, encrypt burst then decrypt burst
    for (int i = 0; i < NRT; i++) begin
      rtKey[i] = {$urandom, $urandom};
      rtPt[i]  = {$urandom, $urandom};
      step(1'b0, 1'b1, 2'b00, rtKey[i], rtPt[i], '0, 1'b0, "R1");
    end
    idle(LAT + 3);
    chk(seen.size() == NRT, "R4 round-trip result count", 64'(seen.size()), 64'(NRT));
    for (int i = 0; i < NRT; i++) begin
      if (i % 4 == 3) step(1'b0, 1'b1, 2'b10, rtKey[i], rtPt[i], rtPt[i], 1'b1, "R3 bypass in burst");
      else if (i < seen.size())
        step(1'b0, 1'b1, 2'b01, rtKey[i], seen[i], rtPt[i], 1'b1, "R2 R5 round trip");
    end
    idle(LAT + 3);

    // R8: reset in the middle of a burst discards the words in flight
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2'b00, katK[i % 5], katP[i % 5], katC[i % 5], 1'b1, "R1");
    step(1'b1, 1'b0, 2'b00, '0, '0, '0, 1'b0, "R8");
    step(1'b1, 1'b0, 2'b00, '0, '0, '0, 1'b0, "R8");
    idle(LAT + 5);
    chk(expQ.size() == 0, "R4 R8 nothing pending", 64'(expQ.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule